// File: doc/BRIEF.md
# UART Modem Control and Section Gating

This block is the control point between a register write/read port and a simple serial transmitter and receiver. It keeps one 32-bit control word. The word holds a global UART enable, separate transmit and receive enables, a data-terminal-ready level, a software request-to-send level, and two flow-control switches. From this word the block drives the active-low RTS and DTR pins and watches the active-low CTS pin through a synchronizer. It then issues two permissions. `tx_start` launches the next character. `rx_allow` lets the receiver recognise a new start bit.

RTS runs in one of two modes. In software mode it follows a bit of the control word. In hardware mode it shows whether the receive FIFO can take another entry. Clearing a transmit or receive enable never cuts a character short. Each section reports itself as running until its in-flight character is done. The shifters and FIFOs sit outside the block and appear only as busy, empty and full flags.

Top module: `uart_mctl`

## Requirements
- R1: After reset the control word reads 0x0000_0300: transmit enable (bit 8) and receive enable (bit 9) are 1, and every other bit is 0, including the global enable (bit 0). A write is visible on `reg_rdata` one clock after the write edge.
- R2: Bits 31:16 and 13:12 always read 0, and writing 1 to them has no effect.
- R3: `dtr_n` is the inverse of bit 10.
- R4: While bit 14 is 0, `rts_n` is the inverse of bit 11.
- R5: While bit 14 is 1, `rts_n` is 0 exactly when `rx_fifo_full` is 0. In that mode bit 11 reads 0, and a write to bit 11 is ignored. The mode that decides this is the one held before the write. The stored bit 11 comes back into use once bit 14 is cleared.
- R6: `tx_start` is 1 only when all of these hold: bit 0 is 1, bit 8 is 1, `tx_busy` is 0, `tx_fifo_empty` is 0, and the CTS condition is met.
- R7: With bit 15 set, the CTS condition is the synchronized `cts_n` being 0. A change on `cts_n` reaches `tx_start` after exactly two rising clock edges.
- R8: With bit 15 clear, `cts_n` has no effect on `tx_start`.
- R9: `rx_allow` is 1 exactly when bits 0 and 9 are both 1.
- R10: `tx_on` and `rx_on` follow their section enable (global AND section bit) one clock later. When the enable drops, the section output stays 1 for as long as its busy input is 1. It falls on the first edge at which the enable is 0 and the busy input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word readback |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_fifo_empty | input | 1 | Transmit FIFO holds nothing |
| tx_start | output | 1 | Permission to launch the next character |
| tx_on | output | 1 | Transmit section running |
| rx_busy | input | 1 | Receiver is assembling a character |
| rx_fifo_full | input | 1 | Receive FIFO has no free entry |
| rx_allow | output | 1 | Permission to recognise a new start bit |
| rx_on | output | 1 | Receive section running |

## Verification
The assertions assume a few things about the inputs. `tx_busy`, `rx_busy`, the FIFO flags and the write strobe must be synchronous to `clk`. Reset must be held for at least one edge. `cts_n` may change at any time, because it reaches the gating only through the synchronizer. The bench keeps within these limits: it changes every input on the falling edge only, and it holds each write strobe for exactly one rising edge. Because of this, each check can count the register stages to its result: one for the control word and the section state, two for CTS.

// File: rtl/uart_mctl_pkg.sv
// Package: bit positions, control-word type and reset value shared by the
// modem-control block. Assumes a control word of at least 16 bits.
package uart_mctl_pkg;

    localparam int CW = 32;

    // Bit positions inside the control word
    localparam int B_CTSEN = 15;
    localparam int B_RTSEN = 14;
    localparam int B_RTS   = 11;
    localparam int B_DTR   = 10;
    localparam int B_RXE   = 9;
    localparam int B_TXE   = 8;
    localparam int B_UEN   = 0;

    typedef struct packed {
        logic ctsen;
        logic rtsen;
        logic sw_rts;
        logic dtr;
        logic rxe;
        logic txe;
        logic uen;
    } mctl_ctrl_t;

    localparam mctl_ctrl_t CTRL_RST = '{
        ctsen: 1'b0, rtsen: 1'b0, sw_rts: 1'b0, dtr: 1'b0,
        rxe: 1'b1, txe: 1'b1, uen: 1'b0
    };

endpackage

// File: rtl/mctl_regs.sv
// Control word storage and readback.
// Holds the defined fields only; reserved positions are never stored.
// The software RTS bit is write-protected while hardware RTS mode is on,
// judged by the mode held before the write. Assumes wr_en is synchronous.
module mctl_regs
    import uart_mctl_pkg::*;
#(
    parameter int W = CW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output mctl_ctrl_t   ctrl
);

    // Update the control fields on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else if (wr_en) begin
            ctrl.ctsen <= wr_data[B_CTSEN];
            ctrl.rtsen <= wr_data[B_RTSEN];
            ctrl.dtr   <= wr_data[B_DTR];
            ctrl.rxe   <= wr_data[B_RXE];
            ctrl.txe   <= wr_data[B_TXE];
            ctrl.uen   <= wr_data[B_UEN];
            if (!ctrl.rtsen)
                ctrl.sw_rts <= wr_data[B_RTS];
        end
    end

    // Assemble the readback word, reserved bits zero
    always_comb begin
        rd_data          = '0;
        rd_data[B_CTSEN] = ctrl.ctsen;
        rd_data[B_RTSEN] = ctrl.rtsen;
        rd_data[B_RTS]   = ctrl.sw_rts & ~ctrl.rtsen;
        rd_data[B_DTR]   = ctrl.dtr;
        rd_data[B_RXE]   = ctrl.rxe;
        rd_data[B_TXE]   = ctrl.txe;
        rd_data[B_UEN]   = ctrl.uen;
    end

    p_rts_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl.rtsen) |=> $stable(ctrl.sw_rts));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[W-1:16] == '0 && rd_data[13:12] == 2'b00));

    p_dtr_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl.dtr == $past(wr_data[B_DTR])));

endmodule

// File: rtl/mctl_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Reset loads RST_VAL into every stage so the output starts in a known state.
// Assumes STAGES >= 2.
module mctl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("mctl_sync needs at least two stages");
        end
    endgenerate

    // Shift the sampled level along the chain
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= {STAGES{RST_VAL}};
        else
            chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/mctl_section.sv
// Running state for one serial section (transmit or receive).
// The section comes on one edge after its enable rises. It goes off only
// at a character boundary: when enable is low and the engine is not busy.
// Assumes busy is synchronous to clk.
module mctl_section (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic busy,
    output logic on
);

    // Track enable, holding on while a character is in flight
    always_ff @(posedge clk) begin
        if (!rst_n)
            on <= 1'b0;
        else
            on <= en | (on & busy);
    end

    p_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (on && busy && !en) |=> on);

    p_idle_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !on);

endmodule

// File: rtl/uart_mctl.sv
// Modem control and start gating for a simple UART.
// Drives the active-low RTS/DTR pins and synchronizes CTS. Issues launch
// permission to the transmitter and start-bit permission to the receiver.
// Clearing a section enable takes effect at the next character boundary.
// Assumes all handshake inputs except cts_n are synchronous to clk.
module uart_mctl
    import uart_mctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [CW-1:0] reg_wdata,
    output logic [CW-1:0] reg_rdata,
    input  logic          cts_n,
    output logic          rts_n,
    output logic          dtr_n,
    input  logic          tx_busy,
    input  logic          tx_fifo_empty,
    output logic          tx_start,
    output logic          tx_on,
    input  logic          rx_busy,
    input  logic          rx_fifo_full,
    output logic          rx_allow,
    output logic          rx_on
);

    localparam int NSEC = 2;

    mctl_ctrl_t      ctrl;
    logic            cts_n_s;
    logic            cts_ok;
    logic [NSEC-1:0] sec_en;
    logic [NSEC-1:0] sec_busy;
    logic [NSEC-1:0] sec_on;

    mctl_regs #(.W(CW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .ctrl    (ctrl)
    );

    mctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cts_n),
        .q_sync  (cts_n_s)
    );

    // Section enables: index 0 transmit, index 1 receive
    always_comb begin
        sec_en[0]   = ctrl.uen & ctrl.txe;
        sec_en[1]   = ctrl.uen & ctrl.rxe;
        sec_busy[0] = tx_busy;
        sec_busy[1] = rx_busy;
    end

    generate
        for (genvar i = 0; i < NSEC; i++) begin : g_sec
            mctl_section u_sec (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (sec_en[i]),
                .busy  (sec_busy[i]),
                .on    (sec_on[i])
            );
        end
    endgenerate

    // Modem pins: RTS by software bit or FIFO room, DTR by control bit
    always_comb begin
        rts_n = ctrl.rtsen ? rx_fifo_full : ~ctrl.sw_rts;
        dtr_n = ~ctrl.dtr;
    end

    // Launch and start-bit permissions
    always_comb begin
        cts_ok   = ~ctrl.ctsen | ~cts_n_s;
        tx_start = sec_en[0] & ~tx_busy & ~tx_fifo_empty & cts_ok;
        rx_allow = sec_en[1];
    end

    assign tx_on = sec_on[0];
    assign rx_on = sec_on[1];

    p_start_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (!tx_busy && !tx_fifo_empty && reg_rdata[B_UEN] && reg_rdata[B_TXE]));

    p_allow_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_allow |-> (reg_rdata[B_UEN] && reg_rdata[B_RXE]));

    p_hw_rts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[B_RTSEN] |-> (rts_n == rx_fifo_full));

endmodule

// File: tb/uart_mctl_test.sv
module uart_mctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cts_n = 1'b1;
    logic        rts_n, dtr_n;
    logic        tx_busy = 1'b0, tx_fifo_empty = 1'b0;
    logic        tx_start, tx_on;
    logic        rx_busy = 1'b0, rx_fifo_full = 1'b0;
    logic        rx_allow, rx_on;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_mctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cts_n(cts_n), .rts_n(rts_n), .dtr_n(dtr_n),
        .tx_busy(tx_busy), .tx_fifo_empty(tx_fifo_empty), .tx_start(tx_start),
        .tx_on(tx_on), .rx_busy(rx_busy), .rx_fifo_full(rx_fifo_full),
        .rx_allow(rx_allow), .rx_on(rx_on)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 reset word", reg_rdata, 32'h0000_0300);
        chk("R4 reset rts_n", rts_n, 1'b1);
        chk("R3 reset dtr_n", dtr_n, 1'b1);
        chk("R6 reset tx_start", tx_start, 1'b0);
        chk("R9 reset rx_allow", rx_allow, 1'b0);
        chk("R10 reset tx_on", tx_on, 1'b0);
    endtask

    task automatic t_regs;
        wr(32'hFFFF_F7FF);
        chk("R2 reserved ignored", reg_rdata, 32'h0000_C701);
        wr(32'h0000_0401);
        chk("R1 readback", reg_rdata, 32'h0000_0401);
        chk("R3 dtr asserted", dtr_n, 1'b0);
        wr(32'h0000_0000);
        chk("R3 dtr released", dtr_n, 1'b1);
    endtask

    task automatic t_rts;
        wr(32'h0000_0800);
        chk("R4 sw rts on", rts_n, 1'b0);
        wr(32'h0000_0000);
        chk("R4 sw rts off", rts_n, 1'b1);
        wr(32'h0000_4800);
        chk("R5 rts bit reads 0", reg_rdata, 32'h0000_4000);
        rx_fifo_full = 1'b0;
        #1 chk("R5 room -> rts asserted", rts_n, 1'b0);
        rx_fifo_full = 1'b1;
        #1 chk("R5 full -> rts released", rts_n, 1'b1);
        wr(32'h0000_4000);
        wr(32'h0000_0000);
        chk("R5 rts write ignored, stored 1 back", rts_n, 1'b0);
        chk("R5 readback after mode off", reg_rdata, 32'h0000_0800);
        rx_fifo_full = 1'b0;
        wr(32'h0000_0000);
    endtask

    task automatic t_tx_gate;
        tx_busy = 1'b0; tx_fifo_empty = 1'b0; cts_n = 1'b1;
        wr(32'h0000_0101);
        chk("R6 start granted", tx_start, 1'b1);
        chk("R8 cts ignored", tx_start, 1'b1);
        tx_busy = 1'b1;
        #1 chk("R6 busy blocks", tx_start, 1'b0);
        tx_busy = 1'b0; tx_fifo_empty = 1'b1;
        #1 chk("R6 empty blocks", tx_start, 1'b0);
        tx_fifo_empty = 1'b0;
        wr(32'h0000_0001);
        chk("R6 txe off blocks", tx_start, 1'b0);
        wr(32'h0000_0100);
        chk("R6 global off blocks", tx_start, 1'b0);
    endtask

    task automatic t_cts;
        cts_n = 1'b1;
        wr(32'h0000_8101);
        cyc(2);
        chk("R7 cts high blocks", tx_start, 1'b0);
        cts_n = 1'b0;
        cyc(1);
        chk("R7 one edge not yet", tx_start, 1'b0);
        cyc(1);
        chk("R7 two edges grants", tx_start, 1'b1);
        cts_n = 1'b1;
        cyc(1);
        chk("R7 release one edge", tx_start, 1'b1);
        cyc(1);
        chk("R7 release two edges", tx_start, 1'b0);
        wr(32'h0000_0101);
        chk("R8 ctsen off ignores cts", tx_start, 1'b1);
    endtask

    task automatic t_rx_gate;
        wr(32'h0000_0201);
        chk("R9 rx allowed", rx_allow, 1'b1);
        wr(32'h0000_0200);
        chk("R9 global off", rx_allow, 1'b0);
        wr(32'h0000_0001);
        chk("R9 rxe off", rx_allow, 1'b0);
    endtask

    task automatic t_sections;
        wr(32'h0000_0301);
        cyc(1);
        chk("R10 tx on", tx_on, 1'b1);
        chk("R10 rx on", rx_on, 1'b1);
        tx_busy = 1'b1; rx_busy = 1'b1;
        wr(32'h0000_0001);
        cyc(3);
        chk("R10 tx held busy", tx_on, 1'b1);
        chk("R10 rx held busy", rx_on, 1'b1);
        chk("R6 no start after disable", tx_start, 1'b0);
        tx_busy = 1'b0;
        cyc(1);
        chk("R10 tx off at boundary", tx_on, 1'b0);
        chk("R10 rx still busy", rx_on, 1'b1);
        rx_busy = 1'b0;
        cyc(1);
        chk("R10 rx off at boundary", rx_on, 1'b0);
        wr(32'h0000_0101);
        cyc(1);
        wr(32'h0000_0001);
        chk("R10 idle tx lags one edge", tx_on, 1'b1);
        cyc(1);
        chk("R10 idle tx off", tx_on, 1'b0);
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_regs();
        t_rts();
        t_tx_gate();
        t_cts();
        t_rx_gate();
        t_sections();
        cyc(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule